// File: doc/BRIEF.md
# Instruction-Cycle Control Sequencer

This block is the control unit of a small 16-bit accumulator machine. A 4-bit sequence counter steps through timing states; each state is decoded into a one-hot timing line, and the opcode field of the instruction register is decoded into eight one-hot opcode lines. From those lines, the captured addressing-mode flag, and the interrupt-cycle flag, the unit forms every register load, the memory read strobe and the 3-bit select of the shared data bus.

The unit performs the fetch, the decode and the indirect-address cycle for any instruction. It carries out the memory-reference AND completely. Every other opcode ends its cycle once the indirect step is done. Instruction word layout: bit 15 is the addressing-mode flag, bits 14:12 are the opcode, and bits 11:0 are the address.

Memory is external. It is addressed by the address register and must return its data in the same cycle. The program counter and accumulator start from parameter values on reset.

Top module: `isc_control_unit`

## Requirements
- R1: While reset is low and just after it is released, the timing state is 0. The program counter equals PC_INIT and the accumulator equals AC_INIT. The address, instruction and data registers are zero. The mode, interrupt-cycle and carry flags are zero.
- R2: In timing state 0, the bus select is 2 (program counter) and the read strobe is low. At the clock edge, the address register takes the program counter.
- R3: In timing state 1, the bus select is 7 (memory) and the read strobe is high. At the clock edge, the instruction register takes the memory word and the program counter increments by one, wrapping at 12 bits.
- R4: In timing state 2, the bus select is 5 (instruction register). At the clock edge, the address register takes instruction bits 11:0 and the mode flag takes instruction bit 15.
- R5: In timing state 3 with the mode flag set and an opcode (bits 14:12) other than 7, the read strobe is high and the bus select is 7. At the clock edge, the address register takes the memory word.
- R6: In timing state 3 with the mode flag clear and an opcode other than 7, the read strobe is low, the bus select is 0 and no register changes. Opcode 0 then moves on to timing state 4.
- R7: For opcode 0, timing state 4 has read strobe high and bus select 7, and the data register takes the memory word. Timing state 5 has read strobe low and bus select 0. The accumulator takes the bitwise AND of the accumulator and the data register, and the next state is 0. The accumulator changes in no other state.
- R8: Every opcode other than 0 returns to timing state 0 after timing state 3. The timing state never exceeds 5.
- R9: In timing state 3 with opcode 7 and the mode flag set, the read strobe is low. The bus select is 4 (accumulator) when instruction bit 10 is 1 and 0 otherwise.
- R10: The write strobe, the carry flag and the interrupt-cycle flag stay 0.
- R11: Start from PC=2CF and AC=2ABC (hex), with memory holding 8B89 at 2CF, 0CDF at B89 and 5875 at CDF. After six cycles the values are AC=0834, AR=CDF, DR=5875, IR=8B89 and PC=2D0, and the timing state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 16 | Memory word at mem_addr, valid in the same cycle |
| mem_addr | output | 12 | Memory address (address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| bus_sel | output | 3 | Common-bus source code |
| t_state | output | 4 | Current sequence counter value |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |
| dr_o | output | 16 | Data register |
| ac_o | output | 16 | Accumulator |
| ind_o | output | 1 | Captured addressing-mode flag |
| e_o | output | 1 | Carry flag |
| r_o | output | 1 | Interrupt-cycle flag |

## Verification
The assertions assume that memory answers the address register in the same cycle with a defined word, and that the interrupt-cycle flag is never raised, since nothing in this subset sets it. The bench keeps to these limits. Its memory array is read combinationally from mem_addr and fully initialised before reset. It is never written during a run, so every expected value comes from a fixed image. The program sweeps all eight opcodes under both addressing modes, with varied address bits so that bit 10 takes both values, after the fixed trace instruction.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OP_W   = 3;
    localparam int SC_W   = 4;
    localparam int NUM_T  = 1 << SC_W;
    localparam int NUM_D  = 1 << OP_W;
    localparam int MODE_BIT = WORD_W - 1;
    localparam int OP_LSB   = ADDR_W;
    localparam int LAST_T   = 5;

    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_AR   = 3'd1,
        BUS_PC   = 3'd2,
        BUS_DR   = 3'd3,
        BUS_AC   = 3'd4,
        BUS_IR   = 3'd5,
        BUS_TR   = 3'd6,
        BUS_MEM  = 3'd7
    } bus_src_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ar;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] dr;
        logic [WORD_W-1:0] ac;
        logic              ind;
        logic              rflag;
        logic              eflag;
    } regs_t;
endpackage

// File: rtl/isc_onehot_dec.sv
module isc_onehot_dec #(
    parameter int IN_W = 3
) (
    input  logic [IN_W-1:0]         code,
    output logic [(1 << IN_W)-1:0]  hot
);
    localparam int OUT_N = 1 << IN_W;

    for (genvar gi = 0; gi < OUT_N; gi++) begin : g_line
        assign hot[gi] = (code == IN_W'(gi));
    end
endmodule

// File: rtl/isc_seq_counter.sv
module isc_seq_counter #(
    parameter int SC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [SC_W-1:0] sc_q
);
    logic [SC_W-1:0] sc_d;

    always_comb begin
        sc_d = clr ? '0 : sc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end
endmodule

// File: rtl/isc_control_unit.sv
module isc_control_unit
    import isc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PC_INIT = '0,
    parameter logic [WORD_W-1:0] AC_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [2:0]        bus_sel,
    output logic [SC_W-1:0]   t_state,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] ir_o,
    output logic [WORD_W-1:0] dr_o,
    output logic [WORD_W-1:0] ac_o,
    output logic              ind_o,
    output logic              e_o,
    output logic              r_o
);
    regs_t regs_q, regs_d;
    logic [SC_W-1:0]  sc_q;
    logic [NUM_T-1:0] t_w;
    logic [NUM_D-1:0] d_w;
    logic             sc_clr;
    logic             rd_w;
    logic [7:1]       src_w;
    logic [2:0]       sel_w;
    logic [WORD_W-1:0] bus_w;
    logic             nr, i_w, b10;

    isc_seq_counter #(.SC_W(SC_W)) u_sc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sc_clr),
        .sc_q  (sc_q)
    );

    isc_onehot_dec #(.IN_W(SC_W)) u_tdec (
        .code (sc_q),
        .hot  (t_w)
    );

    isc_onehot_dec #(.IN_W(OP_W)) u_ddec (
        .code (regs_q.ir[OP_LSB +: OP_W]),
        .hot  (d_w)
    );

    // Control terms
    always_comb begin
        nr  = ~regs_q.rflag;
        i_w = regs_q.ind;
        b10 = regs_q.ir[10];

        rd_w = (nr & t_w[1])
             | (~d_w[7] & i_w & t_w[3])
             | ((d_w[0] | d_w[1] | d_w[2] | d_w[6]) & t_w[4]);

        src_w[BUS_AR]  = (d_w[4] & t_w[4]) | (d_w[5] & t_w[5]);
        src_w[BUS_PC]  = nr & t_w[0];
        src_w[BUS_DR]  = (d_w[2] & t_w[5]) | (d_w[6] & t_w[6]);
        src_w[BUS_AC]  = (d_w[3] & t_w[4]) | (d_w[7] & i_w & t_w[3] & b10);
        src_w[BUS_IR]  = nr & t_w[2];
        src_w[BUS_TR]  = regs_q.rflag & t_w[1];
        src_w[BUS_MEM] = rd_w;

        sel_w[0] = src_w[1] | src_w[3] | src_w[5] | src_w[7];
        sel_w[1] = src_w[2] | src_w[3] | src_w[6] | src_w[7];
        sel_w[2] = src_w[4] | src_w[5] | src_w[6] | src_w[7];

        unique case (sel_w)
            BUS_AR:  bus_w = WORD_W'(regs_q.ar);
            BUS_PC:  bus_w = WORD_W'(regs_q.pc);
            BUS_DR:  bus_w = regs_q.dr;
            BUS_AC:  bus_w = regs_q.ac;
            BUS_IR:  bus_w = regs_q.ir;
            BUS_MEM: bus_w = mem_rdata;
            default: bus_w = '0;
        endcase

        sc_clr = (d_w[0] & t_w[LAST_T]) | (~d_w[0] & t_w[3]);
    end

    // Next register values
    always_comb begin
        regs_d = regs_q;
        if ((nr & t_w[0]) | (nr & t_w[2]) | (~d_w[7] & i_w & t_w[3]))
            regs_d.ar = bus_w[ADDR_W-1:0];
        if (nr & t_w[1]) begin
            regs_d.ir = bus_w;
            regs_d.pc = regs_q.pc + 1'b1;
        end
        if (nr & t_w[2])
            regs_d.ind = regs_q.ir[MODE_BIT];
        if (d_w[0] & t_w[4])
            regs_d.dr = bus_w;
        if (d_w[0] & t_w[LAST_T])
            regs_d.ac = regs_q.ac & regs_q.dr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.pc    <= PC_INIT;
            regs_q.ac    <= AC_INIT;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_addr = regs_q.ar;
    assign mem_rd   = rd_w;
    assign mem_wr   = 1'b0;
    assign bus_sel  = sel_w;
    assign t_state  = sc_q;
    assign pc_o     = regs_q.pc;
    assign ir_o     = regs_q.ir;
    assign dr_o     = regs_q.dr;
    assign ac_o     = regs_q.ac;
    assign ind_o    = regs_q.ind;
    assign e_o      = regs_q.eflag;
    assign r_o      = regs_q.rflag;

    // Assertions
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_w)); // R9
    AST_T_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !(|t_w[NUM_T-1:LAST_T+1])); // R8
    AST_AR_FROM_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sc_q == 0) |=> (regs_q.ar == $past(regs_q.pc))); // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sc_q == 1) |=> (regs_q.pc == $past(regs_q.pc) + 1'b1)); // R3
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sc_q != 1) |=> $stable(regs_q.ir)); // R3
    AST_AC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sc_q != LAST_T) |=> $stable(regs_q.ac)); // R7
    AST_LAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sc_q == LAST_T) |=> (sc_q == 0)); // R7
    AST_OTHER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sc_q == 3 && regs_q.ir[OP_LSB +: OP_W] != 0) |=> (sc_q == 0)); // R8
endmodule

// File: tb/sim_isc_control_unit.sv
`timescale 1ns/1ps
module sim_isc_control_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [2:0]  bus_sel;
    logic [3:0]  t_state;
    logic [11:0] pc_o;
    logic [15:0] ir_o, dr_o, ac_o;
    logic        ind_o, e_o, r_o;

    logic [15:0] mem [0:4095];
    int checks = 0;
    int errors = 0;

    logic [11:0] e_pc, e_ar;
    logic [15:0] e_ir, e_dr, e_ac;
    logic        e_i;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    isc_control_unit #(.PC_INIT(12'h2CF), .AC_INIT(16'h2ABC)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_sel(bus_sel), .t_state(t_state),
        .pc_o(pc_o), .ir_o(ir_o), .dr_o(dr_o), .ac_o(ac_o),
        .ind_o(ind_o), .e_o(e_o), .r_o(r_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_ctl(string req, int t, logic [2:0] sel, logic rd);
        chk(req, "t_state", 32'(t_state), 32'(t));
        chk(req, "bus_sel", 32'(bus_sel), 32'(sel));
        chk(req, "mem_rd", 32'(mem_rd), 32'(rd));
        chk("R10", "mem_wr", 32'(mem_wr), 32'd0);
    endtask

    task automatic chk_regs(string req);
        chk(req, "pc", 32'(pc_o), 32'(e_pc));
        chk(req, "ar", 32'(mem_addr), 32'(e_ar));
        chk(req, "ir", 32'(ir_o), 32'(e_ir));
        chk(req, "dr", 32'(dr_o), 32'(e_dr));
        chk(req, "ac", 32'(ac_o), 32'(e_ac));
        chk(req, "ind", 32'(ind_o), 32'(e_i));
        chk("R10", "e/r flags", {30'd0, e_o, r_o}, 32'd0);
    endtask

    task automatic reset_model();
        e_pc = 12'h2CF; e_ac = 16'h2ABC;
        e_ar = '0; e_ir = '0; e_dr = '0; e_i = 1'b0;
    endtask

    task automatic run_instr();
        logic [2:0] op;
        logic       rd3;
        logic [2:0] sel3;
        chk_ctl("R2", 0, 3'd2, 1'b0);
        tick(); e_ar = e_pc; chk_regs("R2");
        chk_ctl("R3", 1, 3'd7, 1'b1);
        tick(); e_ir = mem[e_ar]; e_pc = e_pc + 12'd1; chk_regs("R3");
        chk_ctl("R4", 2, 3'd5, 1'b0);
        tick(); e_ar = e_ir[11:0]; e_i = e_ir[15]; chk_regs("R4");
        op   = e_ir[14:12];
        rd3  = (op != 3'd7) && e_i;
        sel3 = rd3 ? 3'd7 : ((op == 3'd7 && e_i && e_ir[10]) ? 3'd4 : 3'd0);
        chk_ctl(op == 3'd7 ? "R9" : (e_i ? "R5" : "R6"), 3, sel3, rd3);
        tick(); if (rd3) e_ar = mem[e_ar];
        chk_regs(e_i ? "R5" : "R6");
        if (op != 3'd0) begin
            chk("R8", "t_state after T3", 32'(t_state), 32'd0);
            return;
        end
        chk_ctl("R7", 4, 3'd7, 1'b1);
        tick(); e_dr = mem[e_ar]; chk_regs("R7");
        chk_ctl("R7", 5, 3'd0, 1'b0);
        tick(); e_ac = e_ac & e_dr; chk_regs("R7");
        chk("R7", "t_state after T5", 32'(t_state), 32'd0);
    endtask

    task automatic load_image();
        for (int a = 0; a < 4096; a++)
            mem[a] = 16'((a * 40503 + 7483) ^ (a >> 3));
        mem[12'h2CF] = 16'h8B89;
        mem[12'h2D0] = 16'h7010;
        mem[12'hB89] = 16'h0CDF;
        mem[12'hCDF] = 16'h5875;
        for (int k = 0; k < 48; k++)
            mem[12'h2D1 + k] = {k[3], k[2:0], 12'((k * 347 + 291) ^ (k << 7))};
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        load_image();
        reset_model();
        repeat (3) @(negedge clk);
        chk_regs("R1");
        chk("R1", "t_state in reset", 32'(t_state), 32'd0);
        rst_n = 1'b1;
        chk_regs("R1");
        // Fixed trace instruction
        run_instr();
        chk("R11", "ac", 32'(ac_o), 32'h0834);
        chk("R11", "ar", 32'(mem_addr), 32'h0CDF);
        chk("R11", "dr", 32'(dr_o), 32'h5875);
        chk("R11", "ir", 32'(ir_o), 32'h8B89);
        chk("R11", "pc", 32'(pc_o), 32'h02D0);
        // Sweep of all opcodes and both modes
        for (int n = 0; n < 49; n++) run_instr();
        // Reset taken in the middle of an instruction
        tick(); tick(); tick();
        rst_n = 1'b0;
        #1;
        reset_model();
        chk_regs("R1");
        chk("R1", "t_state mid reset", 32'(t_state), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        run_instr();
        chk("R11", "ac repeat", 32'(ac_o), 32'h0834);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule